// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a core's load/store port and a memory organised as 32-bit words. A request carries a byte address, an access size of one, two or four bytes, a direction, store data, a sign-extension flag, a byte-order select and an alignment-policy select. The unit turns it into word-granular memory accesses: a word address, per-lane byte enables and lane-shifted store data. Loaded bytes come back from the addressed lanes, are put in value order and are extended to 32 bits.

An access of n bytes is aligned when its address is a multiple of n. Under the strict policy, a misaligned request is answered with a trap and never reaches memory. Under the permissive policy, a misaligned request that straddles two words becomes two back-to-back word accesses, lower word first. The bytes of the two words are merged in address order before the response strobe. A misaligned request that fits inside one word uses a single access. Aligned requests take the same time under both policies.

The memory returns read data in the same cycle as the access it is issued with. Writes take effect at the clock edge that ends the access cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid` and `resp_valid` are 0.
- R2: Under the strict policy (`cfg_permissive`=0), a request whose address is not a multiple of its size gives `resp_valid`=1 with `resp_trap`=1 in the cycle after acceptance. No memory access is issued for it, so the stored words are unchanged.
- R3: With `cfg_big_endian`=0, the byte at word offset k uses bits [8k+7:8k] of the memory word. Multi-byte values put their least significant byte at the lowest address.
- R4: With `cfg_big_endian`=1, the byte at word offset k uses bits [31-8k:24-8k] of the memory word. Multi-byte values put their most significant byte at the lowest address.
- R5: `req_size` codes are 0 for one byte, 1 for two bytes and 2 for four bytes; code 3 behaves as four bytes. An aligned request makes exactly one memory access and raises `resp_valid` in the cycle after acceptance, under either policy.
- R6: Under the permissive policy, a misaligned request that spans two words makes two accesses: first the word at address[31:2], then the next word in the following cycle. `resp_valid` rises two cycles after acceptance, and a load returns the bytes of both words merged in address order.
- R7: Under the permissive policy, a misaligned request that lies within one word makes a single access and responds in the cycle after acceptance.
- R8: For stores, the byte enables of each memory access cover only the addressed bytes in that word. For a split store, every byte of either word outside the addressed range keeps its old value.
- R9: A one- or two-byte load is sign-extended to 32 bits when `req_signed`=1 and zero-extended when it is 0.
- R10: `req_ready` is 0 during the second access of a split request, and no new request is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; a request is taken when both are high |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for store, 0 for load |
| req_signed | input | 1 | Sign-extend short loads |
| req_wdata | input | 32 | Store value, right-justified |
| cfg_big_endian | input | 1 | Byte order select |
| cfg_permissive | input | 1 | 1 splits misaligned accesses, 0 traps them |
| mem_valid | output | 1 | Memory access this cycle |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte enables by physical lane |
| mem_wdata | output | 32 | Lane-shifted write data |
| mem_rdata | input | 32 | Read word for the current access |
| resp_valid | output | 1 | Request completed |
| resp_trap | output | 1 | Completed as a misalignment trap |
| resp_rdata | output | 32 | Loaded, extended value |

## Verification
A wrong lane mapping or a wrong byte-order select shows up in the same response as a byte-permuted load value. In a store, it shows up as a changed neighbour byte in the memory word, visible on the next load. A sequencer stuck in or skipping its second-word state shows one cycle later as a wrong `req_ready`, a missing or extra memory access, or a response one cycle off. A wrongly held first word shows up only in the merged value of a split load, two cycles after acceptance. The directed cases therefore straddle word boundaries in both byte orders, and they read back the memory words around every store.

// File: rtl/lsu_pkg.sv
// Package: shared constants, request record and size/lane helpers for the
// load/store alignment unit. Assumes a 32-bit memory word of four lanes.
package lsu_pkg;

    localparam int WORD_BYTES = 4;
    localparam int OFF_W      = 2;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int SPAN_BYTES = 2 * WORD_BYTES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_TAIL = 1'b1
    } seq_state_e;

    // Number of bytes for a size code; the reserved code acts as a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // Address offset held by a physical lane under the chosen byte order.
    function automatic logic [OFF_W-1:0] lane_offset(input logic [OFF_W-1:0] lane,
                                                     input logic big);
        lane_offset = big ? (OFF_W'(WORD_BYTES - 1) - lane) : lane;
    endfunction

endpackage

// File: rtl/lsu_req_decode.sv
// Module: classifies a request by its word offset and size code.
// Assumes sizes of 1, 2 or 4 bytes; the offset is the low address bits.
module lsu_req_decode
    import lsu_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [2:0]       nbytes,
    output logic             misaligned,
    output logic             crosses
);

    // Misalignment: offset not a multiple of the byte count; crossing: the
    // last byte lands past the end of the first word.
    always_comb begin
        nbytes     = size_bytes(size);
        misaligned = ({1'b0, offset} & (nbytes - 3'd1)) != 3'd0;
        crosses    = ({2'b00, offset} + {1'b0, nbytes}) > 4'(WORD_BYTES);
    end

endmodule

// File: rtl/lsu_store_lanes.sv
// Module: places store bytes and enables on the lanes of a two-word span.
// Word 0 is the addressed word, word 1 the next one. Also used on loads
// to report which lanes are read.
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  logic [OFF_W-1:0]      offset,
    input  logic [2:0]            nbytes,
    input  logic                  big,
    input  logic [DATA_W-1:0]     wdata,
    output logic [WORD_BYTES-1:0] be_w0,
    output logic [WORD_BYTES-1:0] be_w1,
    output logic [DATA_W-1:0]     wd_w0,
    output logic [DATA_W-1:0]     wd_w1
);

    logic [SPAN_BYTES-1:0]   span_be;
    logic [8*SPAN_BYTES-1:0] span_data;

    // Map each span byte, in address order, to the store-value byte it carries.
    always_comb begin
        logic [3:0] off4;
        logic [3:0] n4;
        logic [3:0] kk;
        logic [3:0] rel;
        logic [3:0] src;
        off4      = {2'b00, offset};
        n4        = {1'b0, nbytes};
        span_be   = '0;
        span_data = '0;
        for (int k = 0; k < SPAN_BYTES; k++) begin
            kk  = 4'(k);
            rel = kk - off4;
            src = big ? (n4 - 4'd1 - rel) : rel;
            if ((kk >= off4) && (kk < off4 + n4)) begin
                span_be[k]        = 1'b1;
                span_data[8*k +: 8] = wdata[8*src[1:0] +: 8];
            end
        end
    end

    // Route span bytes onto the physical lanes of each word.
    for (genvar p = 0; p < WORD_BYTES; p++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(p);
        logic [OFF_W-1:0] j;
        assign j = lane_offset(LANE, big);
        assign be_w0[p]         = span_be[{1'b0, j}];
        assign be_w1[p]         = span_be[{1'b1, j}];
        assign wd_w0[8*p +: 8]  = span_data[8*{1'b0, j} +: 8];
        assign wd_w1[8*p +: 8]  = span_data[8*{1'b1, j} +: 8];
    end

endmodule

// File: rtl/lsu_load_merge.sv
// Module: assembles a load value from the addressed word and the next
// word, then sign- or zero-extends short loads. Assumes w1 is ignored
// unless the access spans both words.
module lsu_load_merge
    import lsu_pkg::*;
(
    input  logic [DATA_W-1:0] w0,
    input  logic [DATA_W-1:0] w1,
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        nbytes,
    input  logic              big,
    input  logic              sext,
    output logic [DATA_W-1:0] value
);

    logic [8*SPAN_BYTES-1:0] span;

    // Gather both words into address-ordered bytes.
    for (genvar k = 0; k < SPAN_BYTES; k++) begin : g_span
        localparam logic [OFF_W-1:0] OFFS = OFF_W'(k % WORD_BYTES);
        logic [OFF_W-1:0] lane;
        assign lane = lane_offset(OFFS, big);
        if (k < WORD_BYTES) begin : g_lo
            assign span[8*k +: 8] = w0[8*lane +: 8];
        end else begin : g_hi
            assign span[8*k +: 8] = w1[8*lane +: 8];
        end
    end

    // Pick the value bytes in significance order, then fill above them.
    always_comb begin
        logic [3:0] off4;
        logic [3:0] n4;
        logic [3:0] ii;
        logic [3:0] src;
        logic       fill;
        off4  = {2'b00, offset};
        n4    = {1'b0, nbytes};
        value = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            ii  = 4'(i);
            src = big ? (off4 + n4 - 4'd1 - ii) : (off4 + ii);
            if (ii < n4) begin
                value[8*i +: 8] = span[8*src[2:0] +: 8];
            end
        end
        case (nbytes)
            3'd1:    fill = sext & value[7];
            3'd2:    fill = sext & value[15];
            default: fill = 1'b0;
        endcase
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (4'(i) >= n4) begin
                value[8*i +: 8] = {8{fill}};
            end
        end
    end

endmodule

// File: rtl/lsu_seq_ctrl.sv
// Module: sequences one request. It traps, makes a single access, or
// makes two accesses for a permissive word-crossing request. Assumes
// memory read data arrives in the access cycle.
module lsu_seq_ctrl
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic misaligned,
    input  logic crosses,
    input  logic permissive,
    output logic in_tail,
    output logic req_ready,
    output logic mem_valid,
    output logic take_req,
    output logic finish,
    output logic resp_valid,
    output logic resp_trap
);

    seq_state_e state;
    logic       accept;
    logic       trap_now;
    logic       split_now;

    // Decode the current cycle's action from the state and the request class.
    always_comb begin
        in_tail   = (state == ST_TAIL);
        req_ready = !in_tail;
        accept    = req_ready && req_valid;
        trap_now  = accept && misaligned && !permissive;
        split_now = accept && misaligned && permissive && crosses;
        mem_valid = (accept && !trap_now) || in_tail;
        take_req  = split_now;
        finish    = (accept && !trap_now && !split_now) || in_tail;
    end

    // Advance between first and second word access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HEAD;
        end else if (split_now) begin
            state <= ST_TAIL;
        end else if (in_tail) begin
            state <= ST_HEAD;
        end
    end

    // Register the completion strobe and the trap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_trap  <= 1'b0;
        end else begin
            resp_valid <= finish || trap_now;
            resp_trap  <= trap_now;
        end
    end

endmodule

// File: rtl/lsu_align_unit.sv
// Module: top of the load/store alignment and byte-order unit. Assumes a
// word memory with same-cycle read data and writes at the access edge.
// Each request is taken only while req_ready is high.
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic                  req_write,
    input  logic                  req_signed,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  cfg_big_endian,
    input  logic                  cfg_permissive,
    output logic                  mem_valid,
    output logic                  mem_write,
    output logic [ADDR_W-3:0]     mem_addr,
    output logic [WORD_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  resp_valid,
    output logic                  resp_trap,
    output logic [DATA_W-1:0]     resp_rdata
);

    localparam int WADDR_W = ADDR_W - OFF_W;
    localparam logic [WADDR_W-1:0] WA_ONE = WADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              write;
        logic              sext;
        logic [DATA_W-1:0] wdata;
        logic              big;
        logic              perm;
    } req_rec_t;

    req_rec_t          in_req;
    req_rec_t          held_req;
    req_rec_t          cur;
    logic [DATA_W-1:0] held_w0;
    logic              in_tail;
    logic              take_req;
    logic              finish;
    logic [2:0]        nbytes;
    logic              misaligned;
    logic              crosses;
    logic [3:0]        be_w0;
    logic [3:0]        be_w1;
    logic [DATA_W-1:0] wd_w0;
    logic [DATA_W-1:0] wd_w1;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] first_word;

    // Pack the port request and select the record that drives this cycle.
    always_comb begin
        in_req = '{addr: req_addr, size: req_size, write: req_write,
                   sext: req_signed, wdata: req_wdata,
                   big: cfg_big_endian, perm: cfg_permissive};
        cur    = in_tail ? held_req : in_req;
    end

    lsu_req_decode i_decode (
        .offset     (cur.addr[OFF_W-1:0]),
        .size       (cur.size),
        .nbytes     (nbytes),
        .misaligned (misaligned),
        .crosses    (crosses)
    );

    lsu_seq_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .misaligned (misaligned),
        .crosses    (crosses),
        .permissive (cur.perm),
        .in_tail    (in_tail),
        .req_ready  (req_ready),
        .mem_valid  (mem_valid),
        .take_req   (take_req),
        .finish     (finish),
        .resp_valid (resp_valid),
        .resp_trap  (resp_trap)
    );

    lsu_store_lanes i_lanes (
        .offset (cur.addr[OFF_W-1:0]),
        .nbytes (nbytes),
        .big    (cur.big),
        .wdata  (cur.wdata),
        .be_w0  (be_w0),
        .be_w1  (be_w1),
        .wd_w0  (wd_w0),
        .wd_w1  (wd_w1)
    );

    // On the second access the held first word pairs with the live read.
    assign first_word = in_tail ? held_w0 : mem_rdata;

    lsu_load_merge i_merge (
        .w0     (first_word),
        .w1     (mem_rdata),
        .offset (cur.addr[OFF_W-1:0]),
        .nbytes (nbytes),
        .big    (cur.big),
        .sext   (cur.sext),
        .value  (merged)
    );

    // Drive the memory side for the addressed word or the following one.
    always_comb begin
        mem_write = cur.write;
        mem_addr  = in_tail ? (held_req.addr[ADDR_W-1:OFF_W] + WA_ONE)
                            : req_addr[ADDR_W-1:OFF_W];
        mem_be    = in_tail ? be_w1 : be_w0;
        mem_wdata = in_tail ? wd_w1 : wd_w0;
    end

    // Hold the request and its first read word across a split access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_req <= '0;
            held_w0  <= '0;
        end else if (take_req) begin
            held_req <= in_req;
            held_w0  <= mem_rdata;
        end
    end

    // Register the load result when a non-trapping request completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_rdata <= '0;
        end else if (finish) begin
            resp_rdata <= cur.write ? '0 : merged;
        end else if (req_valid && req_ready) begin
            resp_rdata <= '0;
        end
    end

endmodule

// File: rtl/lsu_align_unit_chk.sv
// Module: port-level properties of the alignment unit, bound to the top.
module lsu_align_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              cfg_permissive,
    input logic              mem_valid,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              resp_valid,
    input logic              resp_trap
);

    logic       acc;
    logic [2:0] nb;
    logic       mis;
    logic       crs;

    // Independent classification of the request seen at the ports.
    always_comb begin
        acc = req_valid && req_ready;
        nb  = (req_size == 2'b00) ? 3'd1 : (req_size == 2'b01) ? 3'd2 : 3'd4;
        mis = (req_size == 2'b01) ? req_addr[0]
            : (req_size == 2'b00) ? 1'b0 : (req_addr[1:0] != 2'b00);
        crs = ({2'b00, req_addr[1:0]} + {1'b0, nb}) > 4'd4;
    end

    a_r2_trap_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mis && !cfg_permissive) |-> !mem_valid);

    a_r2_trap_response: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mis && !cfg_permissive) |=> (resp_valid && resp_trap));

    a_r5_aligned_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !mis) |=> (resp_valid && !resp_trap && req_ready));

    a_r6_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mis && cfg_permissive && crs) |=>
        (mem_valid && !req_ready && !resp_valid &&
         mem_addr == $past(req_addr[ADDR_W-1:2]) + 1'b1));

    a_r8_enables_present: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be != 4'b0000));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |-> !mem_valid);

endmodule

bind lsu_align_unit lsu_align_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .cfg_permissive (cfg_permissive),
    .mem_valid      (mem_valid),
    .mem_addr       (mem_addr),
    .mem_be         (mem_be),
    .resp_valid     (resp_valid),
    .resp_trap      (resp_trap)
);

// File: tb/test_lsu_align_unit.sv
module test_lsu_align_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_signed = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        cfg_big_endian = 1'b0;
    logic        cfg_permissive = 1'b0;
    logic        mem_valid;
    logic        mem_write;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        resp_valid;
    logic        resp_trap;
    logic [31:0] resp_rdata;

    logic [31:0] mem [16];
    int n_cmp = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    bit done = 1'b0;

    // Results of the last access.
    int          r_lat;
    int          r_acc;
    logic [31:0] r_data;
    logic        r_trap;
    logic        r_ready_after;

    always #4 clk = ~clk;

    lsu_align_unit i_lsu_align_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_signed(req_signed), .req_wdata(req_wdata),
        .cfg_big_endian(cfg_big_endian), .cfg_permissive(cfg_permissive),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_trap(resp_trap), .resp_rdata(resp_rdata)
    );

    assign mem_rdata = mem[mem_addr[3:0]];

    // Memory model: count accesses and apply enabled write lanes mid-cycle.
    always @(negedge clk) begin
        if (rst_n && mem_valid) begin
            acc_cnt++;
            if (mem_write) begin
                for (int p = 0; p < 4; p++) begin
                    if (mem_be[p]) mem[mem_addr[3:0]][8*p +: 8] <= mem_wdata[8*p +: 8];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic [1:0] size,
                          input logic wr, input logic sx, input logic [31:0] wd,
                          input logic big, input logic perm);
        int a0;
        @(posedge clk); #2;
        a0 = acc_cnt;
        req_addr = addr; req_size = size; req_write = wr; req_signed = sx;
        req_wdata = wd; cfg_big_endian = big; cfg_permissive = perm;
        req_valid = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
        r_ready_after = req_ready;
        r_lat = 1;
        while (!resp_valid && r_lat < 6) begin
            @(posedge clk); #2;
            r_lat++;
        end
        r_acc  = acc_cnt - a0;
        r_data = resp_rdata;
        r_trap = resp_trap;
    endtask

    task automatic t_reset;
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 mem_valid", 32'(mem_valid), 32'd0);
        chk("R1 resp_valid", 32'(resp_valid), 32'd0);
    endtask

    task automatic t_aligned;
        access(32'h8, 2'd2, 0, 0, 0, 0, 0);
        chk("R5 R3 LE word value", r_data, 32'h0B0A0908);
        chk("R5 latency", 32'(r_lat), 32'd1);
        chk("R5 accesses", 32'(r_acc), 32'd1);
        access(32'h4, 2'd2, 0, 0, 0, 0, 1);
        chk("R5 permissive aligned latency", 32'(r_lat), 32'd1);
        chk("R5 permissive aligned accesses", 32'(r_acc), 32'd1);
        access(32'h9, 2'd0, 0, 0, 0, 0, 0);
        chk("R3 LE byte", r_data, 32'h00000009);
        access(32'h9, 2'd0, 0, 0, 0, 1, 0);
        chk("R4 BE byte", r_data, 32'h0000000A);
    endtask

    task automatic t_strict_trap;
        access(32'h5, 2'd1, 0, 0, 0, 0, 0);
        chk("R2 trap flag", 32'(r_trap), 32'd1);
        chk("R2 trap latency", 32'(r_lat), 32'd1);
        chk("R2 no access", 32'(r_acc), 32'd0);
        access(32'h3D, 2'd2, 1, 0, 32'hDEADBEEF, 0, 0);
        chk("R2 store trap flag", 32'(r_trap), 32'd1);
        chk("R2 word untouched", mem[15], 32'h3F3E3D3C);
    endtask

    task automatic t_split_load;
        access(32'h6, 2'd2, 0, 0, 0, 0, 1);
        chk("R6 LE merged", r_data, 32'h09080706);
        chk("R6 latency", 32'(r_lat), 32'd2);
        chk("R6 accesses", 32'(r_acc), 32'd2);
        chk("R10 ready low in tail", 32'(r_ready_after), 32'd0);
        access(32'h6, 2'd2, 0, 0, 0, 1, 1);
        chk("R6 R4 BE merged", r_data, 32'h05040B0A);
        chk("R6 no trap", 32'(r_trap), 32'd0);
    endtask

    task automatic t_inword_misaligned;
        access(32'h1, 2'd1, 0, 0, 0, 0, 1);
        chk("R7 value", r_data, 32'h00000201);
        chk("R7 latency", 32'(r_lat), 32'd1);
        chk("R7 accesses", 32'(r_acc), 32'd1);
    endtask

    task automatic t_extend;
        access(32'h20, 2'd0, 1, 0, 32'h00000085, 0, 0);
        chk("R3 byte store lane", mem[8], 32'h23222185);
        access(32'h20, 2'd0, 0, 1, 0, 0, 0);
        chk("R9 signed byte", r_data, 32'hFFFFFF85);
        access(32'h20, 2'd0, 0, 0, 0, 0, 0);
        chk("R9 unsigned byte", r_data, 32'h00000085);
        access(32'h20, 2'd1, 0, 1, 0, 0, 0);
        chk("R9 signed positive half", r_data, 32'h00002185);
    endtask

    task automatic t_split_store;
        access(32'h2E, 2'd2, 1, 0, 32'hAABBCCDD, 0, 1);
        chk("R8 LE low word", mem[11], 32'hCCDD2D2C);
        chk("R8 LE high word", mem[12], 32'h3332AABB);
        chk("R6 store latency", 32'(r_lat), 32'd2);
        access(32'h37, 2'd1, 1, 0, 32'h00001234, 1, 1);
        chk("R8 R4 BE low word", mem[13], 32'h37363512);
        chk("R8 R4 BE high word", mem[14], 32'h343A3938);
        access(32'h2E, 2'd2, 0, 0, 0, 0, 1);
        chk("R6 reload split store", r_data, 32'hAABBCCDD);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 16; w++) begin
            mem[w] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_aligned();
        t_strict_trap();
        t_split_load();
        t_inword_misaligned();
        t_extend();
        t_split_store();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule